// File: doc/BRIEF.md
# Resumable Non-Maskable Interrupt Trap Controller

This block sits beside the ordinary machine trap logic of a RISC-V hart and handles resumable non-maskable interrupts. A small set of level-sensitive request lines feeds it. While its handler-enable flag is set and any line is high, it takes the request ahead of every ordinary interrupt. In that cycle it saves the current PC, the current privilege and the number of the lowest-numbered active line into its own CSRs, and it redirects the hart to a fixed interrupt vector in machine mode.

Once the handler is entered, the flag drops and ordinary interrupts stay blocked. A synchronous exception raised inside the handler is kept in machine mode and sent to a separate exception vector. A dedicated return instruction brings the hart back: it restores the saved privilege and PC and sets the flag again, after privilege, alignment and privilege-target checks. The hart reaches the four CSRs through a simple combinational read and write port. When the feature parameter is off, any access to those CSRs is flagged as illegal.

Top module: `nmi_trap_unit`

## Requirements
- R1: The CSRs sit at 0x350 (scratch), 0x351 (saved PC), 0x352 (cause) and 0x353 (status). A write with `csr_en` and `csr_we` set takes effect at the next clock edge. `csr_rdata` returns the selected register in the same cycle. Any other address reads as zero.
- R2: The status CSR keeps only bits 12:11, which hold the previous privilege. All of its other bits read as zero whatever was written.
- R3: The request lines are level-sensitive and are never latched. A line that goes low before it is taken leaves no trace: no redirect, no state change.
- R4: While the flag is set and any line is high, `redir_valid` is 1, `redir_pc` equals `IRQ_VEC`, `redir_priv` is 3 (machine) and `irq_grant` is 0, even when `irq_req` is high. The recorded cause is the index of the lowest-numbered high line.
- R5: While `handler_active` is 1, `irq_grant` stays 0 and the request lines cause no redirect.
- R6: Entry takes one clock edge. After that edge `handler_active` is 1, status bits 12:11 hold the privilege from before the edge, the cause holds the line index with bit XLEN-1 clear, and the saved PC holds the `cur_pc` from before the edge. An entry overrides a CSR write to those three registers in the same cycle.
- R7: `exc_valid` while `handler_active` is 1 gives `exc_nmi_vec`=1 (the trap is not delegated), `redir_valid`=1, `redir_pc`=`EXC_VEC` and `redir_priv`=3. While the flag is set, `exc_valid` gives neither `exc_nmi_vec` nor a redirect.
- R8: After reset the flag is set (`handler_active`=0) and all four CSRs read zero.
- R9: The return instruction is the word 0x70200073, presented with `insn_valid`. It is ignored in a cycle that takes an entry or has `exc_valid`. It raises `ret_illegal` when the hart is not in machine mode (privilege code 3). No other word acts as a return.
- R10: With `HAS_C`=0, a return whose saved PC has bits 1:0 nonzero raises `ret_misaligned`, gives no redirect and changes no state.
- R11: A return that passes its checks gives `redir_pc` equal to the saved PC and `redir_priv` equal to status bits 12:11. After the next edge `handler_active` is 0.
- R12: With `HAS_PMP`=0, a return whose saved previous privilege is not machine mode raises `ret_illegal`.
- R13: With `NMI_EN`=0, any access to 0x350 to 0x353 raises `csr_illegal`, reads zero and writes nothing. Every return raises `ret_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_lines | input | NLINES | Level-sensitive NMI request lines |
| irq_req | input | 1 | An ordinary interrupt is pending and enabled |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_pc | input | XLEN | PC of the instruction at the trap point |
| exc_valid | input | 1 | A synchronous exception is being taken this cycle |
| insn_valid | input | 1 | `insn` holds a decoded instruction being retired |
| insn | input | 32 | Instruction word |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |
| csr_illegal | output | 1 | CSR access to an absent NMI register |
| irq_grant | output | 1 | The ordinary interrupt may be taken |
| handler_active | output | 1 | The hart is inside the NMI handler (flag clear) |
| redir_valid | output | 1 | Redirect the hart this cycle |
| redir_pc | output | XLEN | Redirect target |
| redir_priv | output | 2 | Privilege after the redirect |
| exc_nmi_vec | output | 1 | The exception goes to the NMI exception vector, not delegated |
| ret_illegal | output | 1 | The return raises illegal-instruction |
| ret_misaligned | output | 1 | The return raises instruction-address-misaligned |

## Verification
The assertions assume that `cur_pc` and `cur_priv` describe the instruction at the trap point, and that the hart raises `exc_valid` only for synchronous exceptions. They also assume CSR accesses and return instructions are never offered together with a request line that would enter the handler. The stimulus keeps to these rules: CSR accesses run only with every request line low and no instruction valid. The random phase draws lines, interrupt requests, exceptions, privileges and PCs freely but leaves the CSR port idle. This leaves entry, exception and return the only paths that change state in that phase.

// File: rtl/nmi_trap_unit.sv
module nmi_trap_unit #(
  parameter int XLEN = 32,
  parameter int NLINES = 4,
  parameter logic [XLEN-1:0] IRQ_VEC = 'h1000,
  parameter logic [XLEN-1:0] EXC_VEC = 'h1000,
  parameter bit NMI_EN = 1'b1,
  parameter bit HAS_C = 1'b0,
  parameter bit HAS_PMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] nmi_lines,
  input  logic              irq_req,
  input  logic [1:0]        cur_priv,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              exc_valid,
  input  logic              insn_valid,
  input  logic [31:0]       insn,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  output logic              irq_grant,
  output logic              handler_active,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc,
  output logic [1:0]        redir_priv,
  output logic              exc_nmi_vec,
  output logic              ret_illegal,
  output logic              ret_misaligned
);
  localparam int CW = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam logic [31:0] RET_WORD = 32'h7020_0073;
  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [11:0] BASE = 12'h350;

  logic              en;
  logic [XLEN-1:0]   scratch, saved_pc, cause;
  logic [1:0]        mpp;
  logic [CW-1:0]     low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (nmi_lines[i]) low_idx = CW'(i);
  end

  logic take_nmi, is_ret, ret_do, ill_mode, ill_target, ret_ok;
  assign handler_active = NMI_EN && !en;
  assign take_nmi = NMI_EN && en && (|nmi_lines);
  assign irq_grant = irq_req && !take_nmi && !handler_active;
  assign exc_nmi_vec = exc_valid && handler_active;

  assign is_ret = insn_valid && (insn == RET_WORD);
  assign ret_do = is_ret && !exc_valid && !take_nmi;
  assign ill_mode = !NMI_EN || (cur_priv != PRIV_M);
  assign ret_misaligned = ret_do && !ill_mode && !HAS_C && (saved_pc[1:0] != 2'b00);
  assign ill_target = !HAS_PMP && (mpp != PRIV_M);
  assign ret_illegal = ret_do && (ill_mode || (!ret_misaligned && ill_target));
  assign ret_ok = ret_do && !ret_illegal && !ret_misaligned;

  always_comb begin
    redir_valid = 1'b1;
    redir_priv = PRIV_M;
    redir_pc = IRQ_VEC;
    if (take_nmi) begin
      redir_pc = IRQ_VEC;
    end else if (exc_nmi_vec) begin
      redir_pc = EXC_VEC;
    end else if (ret_ok) begin
      redir_pc = saved_pc;
      redir_priv = mpp;
    end else begin
      redir_valid = 1'b0;
      redir_pc = '0;
      redir_priv = 2'b00;
    end
  end

  logic csr_hit, csr_wr;
  assign csr_hit = csr_en && (csr_addr[11:2] == BASE[11:2]);
  assign csr_illegal = csr_hit && !NMI_EN;
  assign csr_wr = csr_hit && NMI_EN && csr_we;

  always_comb begin
    csr_rdata = '0;
    if (csr_hit && NMI_EN)
      case (csr_addr[1:0])
        2'd0: csr_rdata = scratch;
        2'd1: csr_rdata = saved_pc;
        2'd2: csr_rdata = cause;
        default: csr_rdata = XLEN'({mpp, 11'b0});
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b1;
      scratch <= '0;
      saved_pc <= '0;
      cause <= '0;
      mpp <= 2'b00;
    end else if (NMI_EN) begin
      if (csr_wr)
        case (csr_addr[1:0])
          2'd0: scratch <= csr_wdata;
          2'd1: saved_pc <= csr_wdata;
          2'd2: cause <= csr_wdata;
          default: mpp <= csr_wdata[12:11];
        endcase
      if (take_nmi) begin
        en <= 1'b0;
        mpp <= cur_priv;
        cause <= XLEN'(low_idx);
        saved_pc <= cur_pc;
      end else if (ret_ok) begin
        en <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nmi_trap_unit_chk.sv
module nmi_trap_unit_chk #(
  parameter int XLEN = 32,
  parameter int NLINES = 4,
  parameter logic [XLEN-1:0] IRQ_VEC = 'h1000,
  parameter logic [XLEN-1:0] EXC_VEC = 'h1000,
  parameter bit NMI_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] nmi_lines,
  input logic              irq_req,
  input logic [XLEN-1:0]   cur_pc,
  input logic              exc_valid,
  input logic              insn_valid,
  input logic [31:0]       insn,
  input logic              csr_en,
  input logic [11:0]       csr_addr,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              irq_grant,
  input logic              handler_active,
  input logic              redir_valid,
  input logic [XLEN-1:0]   redir_pc,
  input logic [1:0]        redir_priv,
  input logic              ret_illegal,
  input logic              ret_misaligned,
  input logic [XLEN-1:0]   saved_pc
);
  logic entering, returning;
  assign entering = NMI_EN && !handler_active && (nmi_lines != '0);
  assign returning = handler_active && !exc_valid && insn_valid &&
                     insn == 32'h7020_0073 && !ret_illegal && !ret_misaligned;

  a_r4_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    entering |-> redir_valid && redir_pc == IRQ_VEC && redir_priv == 2'b11 && !irq_grant);
  a_r5_no_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    handler_active |-> !irq_grant);
  a_r6_saves_pc: assert property (@(posedge clk) disable iff (!rst_n)
    entering |=> handler_active && saved_pc == $past(cur_pc));
  a_r7_exc_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && handler_active) |-> redir_valid && redir_pc == EXC_VEC && redir_priv == 2'b11);
  a_r11_reenable: assert property (@(posedge clk) disable iff (!rst_n)
    returning |=> !handler_active);
  a_r2_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == 12'h353) |-> (csr_rdata & ~(XLEN'(32'h1800))) == '0);
endmodule

bind nmi_trap_unit nmi_trap_unit_chk #(
  .XLEN(XLEN), .NLINES(NLINES), .IRQ_VEC(IRQ_VEC), .EXC_VEC(EXC_VEC), .NMI_EN(NMI_EN)
) chk (.*);

// File: tb/nmi_trap_unit_test.sv
module nmi_trap_unit_test;
  localparam int XLEN = 32;
  localparam int NL = 4;
  localparam logic [31:0] IV = 32'h0000_1100;
  localparam logic [31:0] EV = 32'h0000_2400;
  localparam logic [31:0] RET = 32'h7020_0073;

  logic clk = 0, rst_n = 0;
  logic [NL-1:0] nmi_lines = '0;
  logic irq_req = 0, exc_valid = 0, insn_valid = 0, csr_en = 0, csr_we = 0;
  logic [1:0] cur_priv = 2'b11;
  logic [31:0] cur_pc = '0, insn = '0, csr_wdata = '0;
  logic [11:0] csr_addr = '0;
  logic [31:0] rdata, rpc, rdata_np, rpc_np, rdata_off, rpc_off;
  logic cill, grant, act, rv, excv, rill, rmis;
  logic cill_np, grant_np, act_np, rv_np, excv_np, rill_np, rmis_np;
  logic cill_off, grant_off, act_off, rv_off, excv_off, rill_off, rmis_off;
  logic [1:0] rpriv, rpriv_np, rpriv_off;

  always #2 clk = ~clk;

  nmi_trap_unit #(.IRQ_VEC(IV), .EXC_VEC(EV)) uut (
    .clk, .rst_n, .nmi_lines, .irq_req, .cur_priv, .cur_pc, .exc_valid, .insn_valid, .insn,
    .csr_en, .csr_we, .csr_addr, .csr_wdata, .csr_rdata(rdata), .csr_illegal(cill),
    .irq_grant(grant), .handler_active(act), .redir_valid(rv), .redir_pc(rpc),
    .redir_priv(rpriv), .exc_nmi_vec(excv), .ret_illegal(rill), .ret_misaligned(rmis));
  nmi_trap_unit #(.IRQ_VEC(IV), .EXC_VEC(EV), .HAS_PMP(1'b0)) alt_np (
    .clk, .rst_n, .nmi_lines, .irq_req, .cur_priv, .cur_pc, .exc_valid, .insn_valid, .insn,
    .csr_en, .csr_we, .csr_addr, .csr_wdata, .csr_rdata(rdata_np), .csr_illegal(cill_np),
    .irq_grant(grant_np), .handler_active(act_np), .redir_valid(rv_np), .redir_pc(rpc_np),
    .redir_priv(rpriv_np), .exc_nmi_vec(excv_np), .ret_illegal(rill_np), .ret_misaligned(rmis_np));
  nmi_trap_unit #(.IRQ_VEC(IV), .EXC_VEC(EV), .NMI_EN(1'b0)) alt_off (
    .clk, .rst_n, .nmi_lines, .irq_req, .cur_priv, .cur_pc, .exc_valid, .insn_valid, .insn,
    .csr_en, .csr_we, .csr_addr, .csr_wdata, .csr_rdata(rdata_off), .csr_illegal(cill_off),
    .irq_grant(grant_off), .handler_active(act_off), .redir_valid(rv_off), .redir_pc(rpc_off),
    .redir_priv(rpriv_off), .exc_nmi_vec(excv_off), .ret_illegal(rill_off), .ret_misaligned(rmis_off));

  int total = 0, bad = 0;
  bit m_en;
  logic [31:0] m_scr, m_epc, m_cause;
  logic [1:0] m_mpp;

  task automatic check(string tag, logic [31:0] actual, logic [31:0] expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  function automatic logic [31:0] lowest(logic [NL-1:0] l);
    for (int i = 0; i < NL; i++) if (l[i]) return i;
    return 0;
  endfunction

  bit e_take, e_ok;
  task automatic eval(string tag);
    bit active, isret, rdo, illa, mis;
    logic [31:0] epc;
    logic [1:0] epriv;
    bit erv;
    #1;
    active = !m_en;
    e_take = m_en && (nmi_lines != 0);
    isret = insn_valid && insn == RET;
    rdo = isret && !exc_valid && !e_take;
    illa = rdo && cur_priv != 2'b11;
    mis = rdo && !illa && m_epc[1:0] != 0;
    e_ok = rdo && !illa && !mis;
    erv = 1; epriv = 2'b11; epc = IV;
    if (e_take) epc = IV;
    else if (exc_valid && active) epc = EV;
    else if (e_ok) begin epc = m_epc; epriv = m_mpp; end
    else begin erv = 0; epc = 0; epriv = 0; end
    check({tag, " R4/R5 irq_grant"}, grant, irq_req && !e_take && !active);
    check({tag, " R5 handler_active"}, act, active);
    check({tag, " R7 exc_nmi_vec"}, excv, exc_valid && active);
    check({tag, " R9 ret_illegal"}, rill, illa);
    check({tag, " R10 ret_misaligned"}, rmis, mis);
    check({tag, " R11 redir_valid"}, rv, erv);
    check({tag, " R11 redir_pc"}, rpc, epc);
    check({tag, " R6 redir_priv"}, rpriv, epriv);
  endtask

  task automatic cycle(string tag);
    eval(tag);
    @(posedge clk);
    if (e_take) begin
      m_en = 0; m_mpp = cur_priv; m_cause = lowest(nmi_lines); m_epc = cur_pc;
    end else if (e_ok) m_en = 1;
    @(negedge clk);
  endtask

  task automatic idle();
    nmi_lines = 0; irq_req = 0; exc_valid = 0; insn_valid = 0; csr_en = 0; csr_we = 0;
  endtask

  task automatic csr_write(logic [11:0] a, logic [31:0] d);
    csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    @(posedge clk);
    case (a)
      12'h350: m_scr = d;
      12'h351: m_epc = d;
      12'h352: m_cause = d;
      12'h353: m_mpp = d[12:11];
      default: ;
    endcase
    @(negedge clk);
    csr_en = 0; csr_we = 0;
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h350: return m_scr;
      12'h351: return m_epc;
      12'h352: return m_cause;
      12'h353: return {19'b0, m_mpp, 11'b0};
      default: return 0;
    endcase
  endfunction

  task automatic csr_read(string tag, logic [11:0] a);
    csr_en = 1; csr_we = 0; csr_addr = a;
    #1 check({tag, " R1 csr_rdata"}, rdata, model_read(a));
    csr_en = 0;
  endtask

  task automatic read_all(string tag);
    csr_read({tag, " scratch"}, 12'h350);
    csr_read({tag, " R6 saved_pc"}, 12'h351);
    csr_read({tag, " R6 cause"}, 12'h352);
    csr_read({tag, " R2 status"}, 12'h353);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd4242);
    m_en = 1; m_scr = 0; m_epc = 0; m_cause = 0; m_mpp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    check("R8 handler_active after reset", act, 0);
    read_all("R8 reset");

    // R1, R2 random CSR traffic
    for (int k = 0; k < 120; k++) begin
      logic [11:0] a;
      a = ($urandom % 6 == 0) ? 12'(($urandom % 8) + 12'h34c) : 12'h350 + 12'($urandom % 4);
      if ($urandom % 2) csr_write(a, $urandom);
      else csr_read("R1 random", a);
    end
    csr_write(12'h353, 32'hFFFF_FFFF);
    csr_read("R2 status all ones", 12'h353);

    // R3 level not latched
    idle(); cur_priv = 0; irq_req = 1;
    cycle("R3 no line, irq granted");
    nmi_lines = 4'b0100; #1; nmi_lines = 0;
    cycle("R3 line dropped");
    check("R3 still outside handler", act, 0);

    // R4 NMI preempts timer interrupt, user mode
    cur_priv = 2'b00; cur_pc = 32'h2000_0104; nmi_lines = 4'b0110; irq_req = 1;
    cycle("R4 preempt timer");
    idle();
    read_all("R6 after entry");
    check("R6 cause bit31 clear", rdata[31], 0);

    // R5 nesting blocked
    cur_priv = 2'b11; cur_pc = IV; nmi_lines = 4'b0001; irq_req = 1;
    cycle("R5 nested request");
    check("R5 cause unchanged", m_cause, 1);
    read_all("R5 after nested");

    // R7 exception inside handler
    idle(); exc_valid = 1; cur_pc = IV + 8;
    cycle("R7 exception in handler");
    idle();

    // R9 wrong word and wrong mode
    insn_valid = 1; insn = 32'h3020_0073; cycle("R9 other word");
    cur_priv = 2'b01; insn = RET; cycle("R9 ret from supervisor");
    // R11 round trip back to user
    cur_priv = 2'b11; cycle("R11 return to user");
    idle();
    check("R11 left handler", act, 0);

    // R10 misaligned
    csr_write(12'h351, 32'h0000_3002);
    cur_priv = 2'b11; insn_valid = 1; insn = RET; cycle("R10 misaligned return");
    idle();

    // R12 no PMP, target not machine
    csr_write(12'h351, 32'h0000_3000);
    csr_write(12'h353, 32'h0000_0000);
    cur_priv = 2'b11; insn_valid = 1; insn = RET;
    #1 check("R12 no-PMP target user illegal", rill_np, 1);
    check("R12 with PMP legal", rill, 0);
    cycle("R12 main return");
    idle();

    // R13 feature off
    csr_en = 1; csr_we = 0; csr_addr = 12'h351;
    #1 check("R13 csr_illegal off", cill_off, 1);
    check("R13 rdata off", rdata_off, 0);
    check("R13 csr_illegal on", cill, 0);
    csr_en = 0;
    csr_write(12'h350, 32'hDEAD_BEEF);
    csr_en = 1; csr_addr = 12'h350;
    #1 check("R13 write ignored when off", rdata_off, 0);
    csr_en = 0;
    insn_valid = 1; insn = RET; cur_priv = 2'b11;
    #1 check("R13 ret illegal off", rill_off, 1);
    idle();

    // random mix
    for (int k = 0; k < 400; k++) begin
      nmi_lines = ($urandom % 4 == 0) ? NL'($urandom) : '0;
      irq_req = $urandom % 2;
      exc_valid = ($urandom % 5 == 0);
      insn_valid = ($urandom % 3 == 0);
      insn = ($urandom % 4 == 0) ? $urandom : RET;
      cur_priv = ($urandom % 3 == 0) ? 2'($urandom) : 2'b11;
      cur_pc = ($urandom % 2) ? $urandom : {$urandom} & 32'hFFFF_FFFC;
      cycle("R4-mix random");
    end
    idle();
    read_all("R6 random end");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule